// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block carries out single reads and writes on the 16-bit internal configuration port of a serial PHY. The PHY side of that port consists of a data-in bus, four strobes (capture-address, capture-data, read, write), an acknowledge line and a data-out bus. Every step on the port is a closed handshake: the master drives the bus, raises one strobe, waits until the PHY raises acknowledge, drops the strobe and waits until acknowledge falls again.

Software-facing logic issues one command at a time through a plain command interface: a valid pulse with a write flag, a 16-bit register address and 16-bit write data. The master answers with a busy level, a one-cycle done pulse, a timeout error flag in the same cycle as done, and the data read back. A write runs three handshakes (address capture, data capture, write strobe); a read runs two (address capture, read strobe). Each wait for acknowledge is a bounded poll, so a PHY that never answers cannot hang the master.

Top module: `phy_cr_master`

## Requirements
- R1: While and right after reset, busy, done and err are low, all four strobes are low and the data-in bus is zero.
- R2: A command is taken only when busy is low and cmdValid is high; busy is high from the next cycle through the done cycle, and cmdValid while busy has no effect on the port or on the result.
- R3: Before any strobe rises, the value it captures is on the data-in bus for SETUP_CYCLES (default 2) cycles with every strobe low, and the bus does not change in the cycle the strobe rises.
- R4: A raised strobe stays high until acknowledge has been seen high; the next setup only starts after acknowledge has been seen low with all strobes down.
- R5: A read runs address capture then the read strobe; during the read setup and strobe the bus is zero, data-out is sampled in the cycle acknowledge is seen high, and rdData holds that value at done and afterwards.
- R6: A write runs address capture, data capture and write strobe in that order, with the write data on the bus during the last two.
- R7: Acknowledge is polled in the first cycle of each wait and then every POLL_GAP cycles, at most POLL_LIMIT times per wait.
- R8: If a wait ends without a match, the access stops: strobes go low, done and err are high together for one cycle, and the master returns to idle ready for the next command; with acknowledge stuck low the address strobe stays high for exactly (POLL_LIMIT-1)*POLL_GAP+1 cycles.
- R9: done is a single-cycle pulse and err is low when every handshake completed.
- R10: At most one strobe is high in any cycle; strobe bit order inside the master is capture-address, capture-data, read, write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, taken when idle |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | 16 | PHY register address |
| cmdWdata | input | 16 | Write payload |
| busy | output | 1 | Access in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout, valid together with done |
| rdData | output | 16 | Last value read from the PHY |
| crDin | output | 16 | Data-in bus to the PHY port |
| crCapAddr | output | 1 | Capture-address strobe |
| crCapData | output | 1 | Capture-data strobe |
| crRd | output | 1 | Read strobe |
| crWr | output | 1 | Write strobe |
| crAck | input | 1 | Acknowledge from the PHY |
| crDout | input | 16 | Read data from the PHY |

## Verification
The master is driven against a responder that answers each strobe after a random number of cycles, and write/read pairs use all-ones, all-zeros, alternating and single-bit payloads at several addresses, so a swapped phase, a wrong bus source or a stuck data bit shows up as a wrong read-back or a wrong strobe sequence. A read of a never-written address separates real data-out sampling from a stale register. Holding acknowledge low and then high exercises the timeout in the rising and the falling wait, and the exact strobe and busy lengths there tell apart an off-by-one in poll count or poll spacing. A command pulsed during a busy access shows whether it leaks onto the port.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  typedef enum logic [1:0] {
    BUS_ZERO = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DATA = 2'd2
  } busSel_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RISE  = 3'd2,
    ST_FALL  = 3'd3,
    ST_DONE  = 3'd4
  } crState_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_XFER = 2'd2
  } crPhase_e;

  // strobe vector bit positions
  localparam int unsigned STB_CAPADDR = 0;
  localparam int unsigned STB_CAPDATA = 1;
  localparam int unsigned STB_READ    = 2;
  localparam int unsigned STB_WRITE   = 3;
  localparam int unsigned STB_COUNT   = 4;

  // control -> datapath
  typedef struct packed {
    logic    latchCmd;
    logic    pollRestart;
    logic    pollActive;
    logic    ackWant;
    logic    captureRd;
    busSel_e busSel;
  } ctlStrobes_t;

endpackage

// File: rtl/phy_cr_dpath.sv
module phy_cr_dpath
  import phy_cr_pkg::*;
#(
  parameter int DW         = 16,
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   ctl,
  input  logic [DW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWdata,
  input  logic          crAck,
  input  logic [DW-1:0] crDout,
  output logic [DW-1:0] crDin,
  output logic [DW-1:0] rdData,
  output logic          pollHit,
  output logic          pollExpire
);

  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam int GCW = $clog2(POLL_GAP + 1);

  logic [DW-1:0]  addrReg;
  logic [DW-1:0]  dataReg;
  logic [PCW-1:0] pollCnt;
  logic           pollNow;
  logic           ackMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else if (ctl.latchCmd) begin
      addrReg <= cmdAddr;
      dataReg <= cmdWdata;
    end
  end

  always_comb begin
    case (ctl.busSel)
      BUS_ADDR: crDin = addrReg;
      BUS_DATA: crDin = dataReg;
      default:  crDin = '0;
    endcase
  end

  // poll spacing: a gap counter only when polls are not back to back
  generate
    if (POLL_GAP > 1) begin : g_gap
      logic [GCW-1:0] gapCnt;
      always_ff @(posedge clk) begin
        if (!rstN || ctl.pollRestart) begin
          gapCnt <= '0;
        end else if (ctl.pollActive) begin
          gapCnt <= (gapCnt == '0) ? GCW'(POLL_GAP - 1) : gapCnt - 1'b1;
        end
      end
      assign pollNow = ctl.pollActive && (gapCnt == '0);
    end else begin : g_nogap
      assign pollNow = ctl.pollActive;
    end
  endgenerate

  assign ackMatch   = (crAck == ctl.ackWant);
  assign pollHit    = pollNow && ackMatch;
  assign pollExpire = pollNow && !ackMatch && (pollCnt == PCW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN || ctl.pollRestart) begin
      pollCnt <= '0;
    end else if (pollNow && !ackMatch && !pollExpire) begin
      pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.captureRd) begin
      rdData <= crDout;
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PCW'(POLL_LIMIT)); // R7

  AST_BUS_SETTLED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pollRestart && !ctl.pollActive) |=> $stable(crDin)); // R3

  AST_CAPTURE_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureRd |-> crAck); // R5

endmodule

// File: rtl/phy_cr_ctrl.sv
module phy_cr_ctrl
  import phy_cr_pkg::*;
#(
  parameter int SETUP_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdWrite,
  input  logic                 pollHit,
  input  logic                 pollExpire,
  input  logic                 crAck,
  output ctlStrobes_t          ctl,
  output logic [STB_COUNT-1:0] strobeVec,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);

  localparam int SCW = $clog2(SETUP_CYCLES + 1);

  crState_e           state, nextState;
  crPhase_e           phase, nextPhase;
  logic               isWrite;
  logic               errReg;
  logic               errSet;
  logic [SCW-1:0]     setupCnt;
  logic [STB_COUNT-1:0] phaseStrobe;

  always_comb begin
    phaseStrobe = '0;
    case (phase)
      PH_ADDR: phaseStrobe[STB_CAPADDR] = 1'b1;
      PH_DATA: phaseStrobe[STB_CAPDATA] = 1'b1;
      default: begin
        if (isWrite) phaseStrobe[STB_WRITE] = 1'b1;
        else         phaseStrobe[STB_READ]  = 1'b1;
      end
    endcase
  end

  always_comb begin
    nextState = state;
    nextPhase = phase;
    ctl       = '0;
    strobeVec = '0;
    errSet    = 1'b0;
    case (phase)
      PH_ADDR: ctl.busSel = BUS_ADDR;
      PH_DATA: ctl.busSel = BUS_DATA;
      default: ctl.busSel = isWrite ? BUS_DATA : BUS_ZERO;
    endcase
    case (state)
      ST_IDLE: begin
        ctl.busSel = BUS_ZERO;
        if (cmdValid) begin
          ctl.latchCmd = 1'b1;
          nextState    = ST_SETUP;
          nextPhase    = PH_ADDR;
        end
      end
      ST_SETUP: begin
        if (setupCnt == SCW'(SETUP_CYCLES - 1)) begin
          nextState       = ST_RISE;
          ctl.pollRestart = 1'b1;
        end
      end
      ST_RISE: begin
        strobeVec      = phaseStrobe;
        ctl.pollActive = 1'b1;
        ctl.ackWant    = 1'b1;
        if (pollHit) begin
          ctl.captureRd   = (phase == PH_XFER) && !isWrite;
          ctl.pollRestart = 1'b1;
          nextState       = ST_FALL;
        end else if (pollExpire) begin
          errSet    = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_FALL: begin
        ctl.pollActive = 1'b1;
        ctl.ackWant    = 1'b0;
        if (pollHit) begin
          if (phase == PH_XFER) begin
            nextState = ST_DONE;
          end else begin
            nextState = ST_SETUP;
            nextPhase = (phase == PH_ADDR && isWrite) ? PH_DATA : PH_XFER;
          end
        end else if (pollExpire) begin
          errSet    = 1'b1;
          nextState = ST_DONE;
        end
      end
      default: begin
        ctl.busSel = BUS_ZERO;
        nextState  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      isWrite  <= 1'b0;
      errReg   <= 1'b0;
      setupCnt <= '0;
    end else begin
      state    <= nextState;
      phase    <= nextPhase;
      setupCnt <= (state == ST_SETUP) ? setupCnt + 1'b1 : '0;
      if (ctl.latchCmd) begin
        isWrite <= cmdWrite;
        errReg  <= 1'b0;
      end else if (errSet) begin
        errReg <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign err  = done && errReg;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeVec)); // R10

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(|strobeVec) && !done) |-> $past(crAck)); // R4

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (strobeVec == '0)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (strobeVec == '0)); // R2

  AST_RISE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|strobeVec) |-> $past(busy)); // R3

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int DW           = 16,
  parameter int SETUP_CYCLES = 2,
  parameter int POLL_LIMIT   = 1000,
  parameter int POLL_GAP     = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic          cmdWrite,
  input  logic [DW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] crDin,
  output logic          crCapAddr,
  output logic          crCapData,
  output logic          crRd,
  output logic          crWr,
  input  logic          crAck,
  input  logic [DW-1:0] crDout
);

  ctlStrobes_t          ctl;
  logic [STB_COUNT-1:0] strobeVec;
  logic                 pollHit;
  logic                 pollExpire;

  phy_cr_ctrl #(
    .SETUP_CYCLES(SETUP_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdWrite  (cmdWrite),
    .pollHit   (pollHit),
    .pollExpire(pollExpire),
    .crAck     (crAck),
    .ctl       (ctl),
    .strobeVec (strobeVec),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  phy_cr_dpath #(
    .DW        (DW),
    .POLL_LIMIT(POLL_LIMIT),
    .POLL_GAP  (POLL_GAP)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cmdAddr   (cmdAddr),
    .cmdWdata  (cmdWdata),
    .crAck     (crAck),
    .crDout    (crDout),
    .crDin     (crDin),
    .rdData    (rdData),
    .pollHit   (pollHit),
    .pollExpire(pollExpire)
  );

  assign crCapAddr = strobeVec[STB_CAPADDR];
  assign crCapData = strobeVec[STB_CAPDATA];
  assign crRd      = strobeVec[STB_READ];
  assign crWr      = strobeVec[STB_WRITE];

endmodule

// File: tb/phy_cr_master_tb_top.sv
module phy_cr_master_tb_top;

  localparam int DW      = 16;
  localparam int SETUP   = 2;
  localparam int LIM     = 12;
  localparam int GAP     = 3;
  localparam int STUCK_STB = (LIM - 1) * GAP + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdWrite = 1'b0;
  logic [DW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdWdata = '0;
  logic          busy, done, err;
  logic [DW-1:0] rdData, crDin;
  logic          crCapAddr, crCapData, crRd, crWr;
  logic          crAck = 1'b0;
  logic [DW-1:0] crDout = '0;
  logic [3:0]    strobeVec;

  always #4 clk = ~clk;

  phy_cr_master #(
    .DW(DW), .SETUP_CYCLES(SETUP), .POLL_LIMIT(LIM), .POLL_GAP(GAP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .busy(busy), .done(done),
    .err(err), .rdData(rdData), .crDin(crDin), .crCapAddr(crCapAddr),
    .crCapData(crCapData), .crRd(crRd), .crWr(crWr), .crAck(crAck),
    .crDout(crDout)
  );

  assign strobeVec = {crWr, crRd, crCapData, crCapAddr};

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- responder model ----------------
  int unsigned stuckMode = 0;   // 0 normal, 1 ack held low, 2 ack held high
  int unsigned dly = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] expMem [16];
  logic [3:0]    rAddr = '0;
  logic [DW-1:0] rData = '0;
  int            seqLog [8];
  int            seqLen = 0;
  int            viol = 0;
  logic [3:0]    prevStb = '0;
  logic          prevAck = 1'b0;
  logic [DW-1:0] bus1 = '0, bus2 = '0;
  logic          quiet1 = 1'b1, quiet2 = 1'b1;

  always @(posedge clk) begin
    if (!rstN) begin
      crAck <= 1'b0;
    end else if (stuckMode == 1) begin
      crAck <= 1'b0;
    end else if (stuckMode == 2) begin
      crAck <= 1'b1;
    end else if (((strobeVec != 0) && !crAck) || ((strobeVec == 0) && crAck)) begin
      if (dly == 0) begin
        crAck <= ~crAck;
        dly   <= $urandom_range(0, 5);
      end else begin
        dly <= dly - 1;
      end
    end
  end

  always @(negedge clk) begin
    logic [3:0] stbRise;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i) * 16'h0111;
    end else begin
      stbRise = strobeVec & ~prevStb;
      if (stbRise != 0) begin
        // R3: two quiet cycles with the same bus value before the strobe
        if (!(quiet1 && quiet2 && bus1 == crDin && bus2 == crDin)) viol++;
        if (seqLen < 8) seqLog[seqLen] = stbRise;
        seqLen++;
        if (stbRise[0]) rAddr = crDin[3:0];
        if (stbRise[1]) rData = crDin;
        if (stbRise[2]) begin
          if (crDin != 0) viol++;
          crDout = mem[rAddr];
        end
        if (stbRise[3]) begin
          if (crDin != rData) viol++;
          mem[rAddr] = crDin;
        end
      end
      // R4: strobe drops only after ack seen high (except on abort)
      if ((prevStb != 0) && (strobeVec == 0) && !done && !prevAck) viol++;
    end
    prevStb = strobeVec;
    prevAck = crAck;
    bus2 = bus1;
    bus1 = crDin;
    quiet2 = quiet1;
    quiet1 = (strobeVec == 0);
  end

  // ---------------- command driver ----------------
  task automatic runCmd(input bit wr, input logic [DW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output bit e,
                        output int stbCycles, output int busyCycles, output bit gotDone);
    rd = '0; e = 1'b0;
    @(negedge clk);
    seqLen = 0; viol = 0;
    cmdValid = 1'b1; cmdWrite = wr; cmdAddr = a; cmdWdata = d;
    @(negedge clk);
    cmdValid = 1'b0;
    stbCycles = 0; busyCycles = 0; gotDone = 1'b0;
    for (int i = 0; i < 3000 && !gotDone; i++) begin
      if (busy) busyCycles++;
      if (strobeVec != 0) stbCycles++;
      if (done) begin
        gotDone = 1'b1;
        e = err;
        rd = rdData;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic checkPulseEnd(input string req);
    @(negedge clk);
    check(req, "done low after pulse", done, 0);
    check(req, "busy low after done", busy, 0);
  endtask

  task automatic testReset();
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "strobes in reset", strobeVec, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", busy, 0);
    check("R1", "err after reset", err, 0);
    check("R1", "crDin after reset", crDin, 0);
    check("R1", "strobes after reset", strobeVec, 0);
  endtask

  task automatic testWrite(input logic [DW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] rd; bit e, g; int s, b;
    runCmd(1'b1, a, d, rd, e, s, b, g);
    expMem[a[3:0]] = d;
    check("R6", "write done seen", g, 1);
    check("R9", "write err", e, 0);
    check("R6", "write strobe count", seqLen, 3);
    check("R6", "write 1st strobe addr", seqLog[0], 1);
    check("R6", "write 2nd strobe data", seqLog[1], 2);
    check("R6", "write 3rd strobe write", seqLog[2], 8);
    check("R3", "write protocol violations", viol, 0);
    checkPulseEnd("R9");
  endtask

  task automatic testRead(input logic [DW-1:0] a);
    logic [DW-1:0] rd; bit e, g; int s, b;
    runCmd(1'b0, a, 16'hffff, rd, e, s, b, g);
    check("R5", "read done seen", g, 1);
    check("R9", "read err", e, 0);
    check("R5", "read data", rd, expMem[a[3:0]]);
    check("R5", "read strobe count", seqLen, 2);
    check("R5", "read 2nd strobe is read", seqLog[1], 4);
    check("R4", "read protocol violations", viol, 0);
    checkPulseEnd("R9");
    repeat (3) @(negedge clk);
    check("R5", "rdData held", rdData, expMem[a[3:0]]);
  endtask

  task automatic testBusyIgnore();
    // R2: second request during a running write must not reach the port
    @(negedge clk);
    seqLen = 0; viol = 0;
    cmdValid = 1'b1; cmdWrite = 1'b1; cmdAddr = 16'h0003; cmdWdata = 16'h3c3c;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    cmdValid = 1'b1; cmdWrite = 1'b1; cmdAddr = 16'h0005; cmdWdata = 16'hdead;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R2", "busy during access", busy, 1);
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    expMem[3] = 16'h3c3c;
    repeat (20) @(negedge clk);
    check("R2", "strobes for one access only", seqLen, 3);
    check("R2", "idle after single access", busy, 0);
    testRead(16'h0005);
    testRead(16'h0003);
  endtask

  task automatic testStuck(input int unsigned mode, input int expStb, input int expBusy, input string what);
    logic [DW-1:0] rd; bit e, g; int s, b;
    @(negedge clk);
    stuckMode = mode;
    repeat (3) @(negedge clk);
    runCmd(1'b0, 16'h0002, 16'h0000, rd, e, s, b, g);
    check("R8", {what, " done seen"}, g, 1);
    check("R8", {what, " err"}, e, 1);
    check("R8", {what, " strobes low at done"}, strobeVec, 0);
    check("R7", {what, " strobe cycles"}, s, expStb);
    check("R7", {what, " busy cycles"}, b, expBusy);
    checkPulseEnd("R8");
    stuckMode = 0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) expMem[i] = 16'h1000 + 16'(i) * 16'h0111;
    repeat (3) @(negedge clk);
    testReset();
    testRead(16'h0007);            // never written
    testWrite(16'h0001, 16'hffff);
    testRead(16'h0001);
    testWrite(16'h0002, 16'h0000);
    testRead(16'h0002);
    testWrite(16'h000a, 16'ha5a5);
    testWrite(16'h000f, 16'h0100);
    testRead(16'h000f);
    testRead(16'h000a);
    testBusyIgnore();
    testStuck(1, STUCK_STB, SETUP + STUCK_STB + 1, "ack stuck low");
    testStuck(2, 1, SETUP + 1 + STUCK_STB + 1, "ack stuck high");
    testWrite(16'h0004, 16'h5a5a); // recovery after timeout, R8
    testRead(16'h0004);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nBad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule